// File: doc/BRIEF.md
# Translation Buffer Maintenance with Rotating Replacement Slot

This block owns the entries of a fully associative address translation buffer and the four software-visible registers used to maintain them: a slot selector (Index), a rotating replacement slot (Random), and the two staging halves of an entry (EntryHi with page number and address-space tag, EntryLo with frame number and flags). A one-hot operation strobe asks for one of four maintenance actions. Read copies a slot into the staging registers. Indexed write stores the staging registers into the slot named by Index. Random write stores them into the slot named by Random. Probe searches the buffer for the staged page number and tag and reports the slot.

The replacement slot steps down by one on each advance pulse. It runs from the top slot to a floor of 8 and then starts again at the top, so the low eight slots are never chosen for replacement and stay free for entries that must not be evicted. A separate combinational read port lets a lookup unit elsewhere see any entry.

Top module: `tlb_maint_top`

## Requirements
- R1: After reset Random reads 0x00003F00 (slot 63 in bits [13:8]); Index, EntryHi, EntryLo and every buffer entry read zero.
- R2: Each cycle with `rnd_adv_i` high, the Random slot field drops by one. From slot 8 it goes to slot 63. Without the pulse it holds.
- R3: Random is read-only. A software write to it (select 1) leaves its value unchanged.
- R4: A software write changes only bits set in both `reg_wmask_i` and the writable set of the selected register. Index (select 0) has writable bits [13:8] and keeps its miss flag in bit 31. EntryHi (select 2) has writable bits [31:6]: page number [31:12] and tag [11:6]. EntryLo (select 3) has writable bits [31:8]: frame [31:12], noncacheable bit 11, dirty bit 10, valid bit 9, global bit 8. Unwritable bits read zero.
- R5: An indexed write (op bit 1) stores EntryHi and EntryLo into the slot in Index[13:8]. The lookup port shows an entry from the clock edge after it is written.
- R6: A random write (op bit 2) stores EntryHi and EntryLo into the slot Random names in the cycle of the strobe, even if Random advances in that same cycle.
- R7: A read (op bit 0) loads EntryHi and EntryLo from the slot in Index[13:8], each limited to its writable bits.
- R8: A probe (op bit 3) hits an entry whose page number equals EntryHi[31:12] and whose global bit is set or whose tag equals EntryHi[11:6]. On a hit, Index becomes the slot number shifted left by 8. When several entries match, the lowest slot wins.
- R9: A probe that finds no match writes 0x80000000 to Index.
- R10: A probe strobed in the cycle right after a write sees the entry that write stored.
- R11: An operation strobe with more than one bit set does nothing: Index, EntryHi, EntryLo and the buffer stay unchanged.
- R12: When an operation and a software write target the same register in one cycle, the operation's result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | One-hot operation: bit0 read, bit1 indexed write, bit2 random write, bit3 probe |
| reg_we_i | input | 1 | Software register write strobe |
| reg_sel_i | input | 2 | Register select: 0 Index, 1 Random, 2 EntryHi, 3 EntryLo |
| reg_wdata_i | input | 32 | Software write data |
| reg_wmask_i | input | 32 | Per-bit write enable for the software write |
| rnd_adv_i | input | 1 | Advance pulse for the replacement slot |
| lk_slot_i | input | 6 | Slot selected on the lookup read port |
| index_o | output | 32 | Index register value |
| random_o | output | 32 | Random register value |
| entry_hi_o | output | 32 | EntryHi register value |
| entry_lo_o | output | 32 | EntryLo register value |
| lk_hi_o | output | 32 | High half of the entry at `lk_slot_i` |
| lk_lo_o | output | 32 | Low half of the entry at `lk_slot_i` |

## Verification
The bench drives the replacement counter across its full period. A counter that wrapped at zero instead of at the floor, or that skipped the top slot, would drift from the model in the wrap cycle. Probes are aimed at a slot written one cycle earlier, at an entry that hits only by its global flag, and at two matching entries at once; a stale array read, an ignored global bit or a highest-slot priority would each put a wrong slot in Index. A random write is strobed together with an advance pulse to catch a design that writes to the post-decrement slot. Multi-bit strobes and a software Index write that collides with a probe expose decoding and priority slips.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef struct packed {
      logic [31:0] hi;
      logic [31:0] lo;
   } tlb_entry_t;

   typedef enum logic [1:0] {
      SEL_INDEX  = 2'd0,
      SEL_RANDOM = 2'd1,
      SEL_HI     = 2'd2,
      SEL_LO     = 2'd3
   } tlb_reg_sel_e;

   localparam int OP_READ  = 0;
   localparam int OP_WIDX  = 1;
   localparam int OP_WRND  = 2;
   localparam int OP_PROBE = 3;
   localparam int OP_W     = 4;

endpackage

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
   parameter int IDX_W = 6,
   parameter int FLOOR = 8,
   parameter int TOP   = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [IDX_W-1:0] slot_o
);
   localparam logic [IDX_W-1:0] FLOOR_V = IDX_W'(FLOOR);
   localparam logic [IDX_W-1:0] TOP_V   = IDX_W'(TOP);

   logic [IDX_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= TOP_V;
      end else if (adv_i) begin
         if (slot_q == FLOOR_V) slot_q <= TOP_V;
         else                   slot_q <= slot_q - 1'b1;
      end
   end

   assign slot_o = slot_q;
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we_i,
   input  logic [IDX_W-1:0]               wslot_i,
   input  tlb_entry_t                     wdata_i,
   output tlb_entry_t [ENTRIES-1:0]       ent_o
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      tlb_entry_t ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   ent_q <= '0;
         else if (we_i && wslot_i == IDX_W'(g))        ent_q <= wdata_i;
      end
      assign ent_o[g] = ent_q;
   end
endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
   import tlb_pkg::*;
#(
   parameter int ENTRIES   = 64,
   parameter int IDX_W     = 6,
   parameter int VPN_LSB   = 12,
   parameter int ASID_LSB  = 6,
   parameter int ASID_W    = 6,
   parameter int GLOB_BIT  = 8,
   parameter bit LOW_FIRST = 1'b1
) (
   input  tlb_entry_t [ENTRIES-1:0] ent_i,
   input  logic [31:0]              key_i,
   output logic                     hit_o,
   output logic [IDX_W-1:0]         slot_o
);
   localparam int VPN_W = 32 - VPN_LSB;

   logic [ENTRIES-1:0] match;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic vpn_eq, asid_eq;
      assign vpn_eq  = ent_i[g].hi[VPN_LSB +: VPN_W] == key_i[VPN_LSB +: VPN_W];
      assign asid_eq = ent_i[g].hi[ASID_LSB +: ASID_W] == key_i[ASID_LSB +: ASID_W];
      assign match[g] = vpn_eq && (ent_i[g].lo[GLOB_BIT] || asid_eq);
   end

   assign hit_o = |match;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         slot_o = '0;
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) slot_o = IDX_W'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         slot_o = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) slot_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_maint_top.sv
module tlb_maint_top
   import tlb_pkg::*;
#(
   parameter int ENTRIES   = 64,
   parameter int RND_FLOOR = 8,
   parameter int SLOT_LSB  = 8,
   parameter int VPN_LSB   = 12,
   parameter int ASID_LSB  = 6,
   parameter int ASID_W    = 6,
   parameter int FLAG_LSB  = 8,
   parameter int MISS_BIT  = 31,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_i,
   input  logic             reg_we_i,
   input  logic [1:0]       reg_sel_i,
   input  logic [31:0]      reg_wdata_i,
   input  logic [31:0]      reg_wmask_i,
   input  logic             rnd_adv_i,
   input  logic [IDX_W-1:0] lk_slot_i,
   output logic [31:0]      index_o,
   output logic [31:0]      random_o,
   output logic [31:0]      entry_hi_o,
   output logic [31:0]      entry_lo_o,
   output logic [31:0]      lk_hi_o,
   output logic [31:0]      lk_lo_o
);
   localparam int          VPN_W    = 32 - VPN_LSB;
   localparam int          RND_TOP  = ENTRIES - 1;
   localparam logic [31:0] IDX_WM   = ((32'd1 << IDX_W) - 32'd1) << SLOT_LSB;
   localparam logic [31:0] HI_WM    = (((32'd1 << VPN_W) - 32'd1) << VPN_LSB)
                                    | (((32'd1 << ASID_W) - 32'd1) << ASID_LSB);
   localparam logic [31:0] LO_WM    = 32'hFFFF_FFFF << FLAG_LSB;
   localparam logic [31:0] MISS_V   = 32'd1 << MISS_BIT;

   // elaboration-time parameter checks
   if (ENTRIES != (1 << IDX_W)) begin : g_bad_entries
      $error("ENTRIES must be a power of two");
   end
   if (RND_FLOOR < 0 || RND_FLOOR >= RND_TOP) begin : g_bad_floor
      $error("RND_FLOOR must lie below the top slot");
   end
   if (SLOT_LSB + IDX_W > MISS_BIT) begin : g_bad_slot
      $error("slot field overlaps the miss flag");
   end
   if (ASID_LSB + ASID_W > VPN_LSB) begin : g_bad_tag
      $error("tag field overlaps the page number");
   end
   if (FLAG_LSB >= VPN_LSB) begin : g_bad_flag
      $error("flag field overlaps the frame number");
   end

   // registers
   logic [31:0] idx_q, hi_q, lo_q;
   logic [31:0] idx_n, hi_n, lo_n;

   // operation decode: exactly one strobe bit or nothing happens
   logic op_ok, do_rd, do_wi, do_wr, do_pr;
   assign op_ok = $onehot(op_i);
   assign do_rd = op_ok && op_i[OP_READ];
   assign do_wi = op_ok && op_i[OP_WIDX];
   assign do_wr = op_ok && op_i[OP_WRND];
   assign do_pr = op_ok && op_i[OP_PROBE];

   // replacement slot
   logic [IDX_W-1:0] rnd_slot;
   tlb_rand_ctr #(
      .IDX_W (IDX_W),
      .FLOOR (RND_FLOOR),
      .TOP   (RND_TOP)
   ) u_rnd (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (rnd_adv_i),
      .slot_o (rnd_slot)
   );

   // entry storage
   logic [IDX_W-1:0]         idx_slot;
   logic                     arr_we;
   logic [IDX_W-1:0]         arr_wslot;
   tlb_entry_t               arr_wdata;
   tlb_entry_t [ENTRIES-1:0] ents;

   assign idx_slot  = idx_q[SLOT_LSB +: IDX_W];
   assign arr_we    = do_wi || do_wr;
   assign arr_wslot = do_wr ? rnd_slot : idx_slot;
   assign arr_wdata = '{hi: hi_q, lo: lo_q};

   tlb_entry_array #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (arr_we),
      .wslot_i (arr_wslot),
      .wdata_i (arr_wdata),
      .ent_o   (ents)
   );

   // associative search
   logic             pr_hit;
   logic [IDX_W-1:0] pr_slot;

   tlb_probe #(
      .ENTRIES   (ENTRIES),
      .IDX_W     (IDX_W),
      .VPN_LSB   (VPN_LSB),
      .ASID_LSB  (ASID_LSB),
      .ASID_W    (ASID_W),
      .GLOB_BIT  (FLAG_LSB),
      .LOW_FIRST (LOW_FIRST)
   ) u_probe (
      .ent_i  (ents),
      .key_i  (hi_q),
      .hit_o  (pr_hit),
      .slot_o (pr_slot)
   );

   // next-state: software write first, maintenance result overrides
   logic [31:0] sw_m;
   logic [31:0] pr_idx;
   tlb_entry_t  rd_ent;

   assign sw_m   = reg_wmask_i;
   assign rd_ent = ents[idx_slot];

   always_comb begin
      pr_idx = '0;
      if (pr_hit) pr_idx[SLOT_LSB +: IDX_W] = pr_slot;
      else        pr_idx = MISS_V;
   end

   always_comb begin
      idx_n = idx_q;
      hi_n  = hi_q;
      lo_n  = lo_q;
      if (reg_we_i) begin
         unique case (tlb_reg_sel_e'(reg_sel_i))
            SEL_INDEX:  idx_n = (idx_q & ~(sw_m & IDX_WM)) | (reg_wdata_i & sw_m & IDX_WM);
            SEL_HI:     hi_n  = (hi_q  & ~(sw_m & HI_WM))  | (reg_wdata_i & sw_m & HI_WM);
            SEL_LO:     lo_n  = (lo_q  & ~(sw_m & LO_WM))  | (reg_wdata_i & sw_m & LO_WM);
            SEL_RANDOM: ;
            default:    ;
         endcase
      end
      if (do_rd) begin
         hi_n = rd_ent.hi & HI_WM;
         lo_n = rd_ent.lo & LO_WM;
      end
      if (do_pr) idx_n = pr_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else begin
         idx_q <= idx_n;
         hi_q  <= hi_n;
         lo_q  <= lo_n;
      end
   end

   // outputs
   always_comb begin
      random_o = '0;
      random_o[SLOT_LSB +: IDX_W] = rnd_slot;
   end

   assign index_o    = idx_q;
   assign entry_hi_o = hi_q;
   assign entry_lo_o = lo_q;
   assign lk_hi_o    = ents[lk_slot_i].hi;
   assign lk_lo_o    = ents[lk_slot_i].lo;

endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk #(
   parameter int IDX_W     = 6,
   parameter int RND_FLOOR = 8,
   parameter int SLOT_LSB  = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic [3:0]  op_i,
   input logic        reg_we_i,
   input logic        rnd_adv_i,
   input logic [31:0] index_o,
   input logic [31:0] random_o,
   input logic [31:0] entry_hi_o,
   input logic [31:0] entry_lo_o
);
   localparam logic [IDX_W-1:0] TOP_V   = {IDX_W{1'b1}};
   localparam logic [IDX_W-1:0] FLOOR_V = IDX_W'(RND_FLOOR);
   localparam logic [31:0]      SLOT_M  = ((32'd1 << IDX_W) - 32'd1) << SLOT_LSB;

   logic [IDX_W-1:0] rfld;
   assign rfld = random_o[SLOT_LSB +: IDX_W];

   p_rand_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rfld >= FLOOR_V && (random_o & ~SLOT_M) == 32'd0);

   p_rand_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_adv_i && rfld == FLOOR_V |=> rfld == TOP_V);

   p_rand_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_adv_i && rfld != FLOOR_V |=> rfld == $past(rfld) - 1'b1);

   p_rand_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rnd_adv_i |=> $stable(random_o));

   p_probe_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(op_i) && op_i[3] |=>
         (index_o[31] ? index_o[30:0] == 31'd0 : (index_o & ~SLOT_M) == 32'd0));

   p_bad_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$onehot0(op_i) && !reg_we_i |=>
         $stable(index_o) && $stable(entry_hi_o) && $stable(entry_lo_o));
endmodule

bind tlb_maint_top tlb_maint_chk #(
   .IDX_W     (IDX_W),
   .RND_FLOOR (RND_FLOOR),
   .SLOT_LSB  (SLOT_LSB)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_i       (op_i),
   .reg_we_i   (reg_we_i),
   .rnd_adv_i  (rnd_adv_i),
   .index_o    (index_o),
   .random_o   (random_o),
   .entry_hi_o (entry_hi_o),
   .entry_lo_o (entry_lo_o)
);

// File: tb/tlb_maint_top_tb.sv
module tlb_maint_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = '0;
   logic        we = 1'b0;
   logic [1:0]  sel = '0;
   logic [31:0] wd = '0;
   logic [31:0] wm = '0;
   logic        adv = 1'b0;
   logic [5:0]  lk = '0;
   logic [31:0] index_o, random_o, entry_hi_o, entry_lo_o, lk_hi_o, lk_lo_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   tlb_maint_top u_dut (
      .clk (clk), .rst_n (rst_n), .op_i (op), .reg_we_i (we), .reg_sel_i (sel),
      .reg_wdata_i (wd), .reg_wmask_i (wm), .rnd_adv_i (adv), .lk_slot_i (lk),
      .index_o (index_o), .random_o (random_o), .entry_hi_o (entry_hi_o),
      .entry_lo_o (entry_lo_o), .lk_hi_o (lk_hi_o), .lk_lo_o (lk_lo_o)
   );

   // behavioural reference model
   int          m_rnd;
   logic [31:0] m_idx, m_hi, m_lo;
   logic [31:0] m_eh [64];
   logic [31:0] m_el [64];

   always @(posedge clk) begin
      logic [31:0] n_idx, n_hi, n_lo;
      int s;
      bit found;
      if (!rst_n) begin
         m_rnd = 63; m_idx = 0; m_hi = 0; m_lo = 0;
         for (int i = 0; i < 64; i++) begin m_eh[i] = 0; m_el[i] = 0; end
      end else begin
         n_idx = m_idx; n_hi = m_hi; n_lo = m_lo;
         if (we) begin
            if (sel == 0) n_idx = (m_idx & ~(wm & 32'h3F00)) | (wd & wm & 32'h3F00);
            if (sel == 2) n_hi  = (m_hi & ~(wm & 32'hFFFFFFC0)) | (wd & wm & 32'hFFFFFFC0);
            if (sel == 3) n_lo  = (m_lo & ~(wm & 32'hFFFFFF00)) | (wd & wm & 32'hFFFFFF00);
         end
         s = int'((m_idx >> 8) & 32'h3F);
         if ($countones(op) == 1) begin
            if (op[0]) begin n_hi = m_eh[s]; n_lo = m_el[s]; end
            if (op[1]) begin m_eh[s] = m_hi; m_el[s] = m_lo; end
            if (op[2]) begin m_eh[m_rnd] = m_hi; m_el[m_rnd] = m_lo; end
            if (op[3]) begin
               found = 0;
               n_idx = 32'h8000_0000;
               for (int i = 0; i < 64; i++) begin
                  if (!found && m_eh[i][31:12] == m_hi[31:12] &&
                      (m_el[i][8] || m_eh[i][11:6] == m_hi[11:6])) begin
                     found = 1;
                     n_idx = 32'(i) << 8;
                  end
               end
            end
         end
         if (adv) m_rnd = (m_rnd == 8) ? 63 : m_rnd - 1;
         m_idx = n_idx; m_hi = n_hi; m_lo = n_lo;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 model random", random_o, 32'(m_rnd) << 8);
         chk("R8 model index", index_o, m_idx);
         chk("R7 model entry_hi", entry_hi_o, m_hi);
         chk("R7 model entry_lo", entry_lo_o, m_lo);
         chk("R5 model lookup hi", lk_hi_o, m_eh[lk]);
         chk("R5 model lookup lo", lk_lo_o, m_el[lk]);
      end
   end

   task automatic cyc(input logic [3:0] o, input logic w, input logic [1:0] s,
                      input logic [31:0] d, input logic [31:0] m, input logic a);
      op = o; we = w; sel = s; wd = d; wm = m; adv = a;
      @(posedge clk); #2;
      op = '0; we = 1'b0; adv = 1'b0;
   endtask

   task automatic wreg(input logic [1:0] s, input logic [31:0] d);
      cyc(4'b0000, 1'b1, s, d, 32'hFFFF_FFFF, 1'b0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      chk("R1 random", random_o, 32'h0000_3F00);
      chk("R1 index", index_o, 32'h0);
      chk("R1 entry_hi", entry_hi_o, 32'h0);
      chk("R1 entry_lo", entry_lo_o, 32'h0);
      lk = 6'd0; #1;
      chk("R1 slot0 empty", lk_lo_o, 32'h0);
      // R3 software write to Random is discarded
      wreg(2'd1, 32'hFFFF_FFFF);
      chk("R3 random unchanged", random_o, 32'h0000_3F00);
      // R4 masked writes
      wreg(2'd2, 32'hFFFF_FFFF);
      chk("R4 hi writable bits", entry_hi_o, 32'hFFFF_FFC0);
      cyc(4'b0000, 1'b1, 2'd2, 32'h0, 32'h0000_FFFF, 1'b0);
      chk("R4 hi partial mask", entry_hi_o, 32'hFFFF_0000);
      // R2 count down to floor and wrap
      for (int i = 0; i < 55; i++) cyc(4'b0000, 1'b0, 2'd0, 0, 0, 1'b1);
      chk("R2 reached floor", random_o, 32'h0000_0800);
      cyc(4'b0000, 1'b0, 2'd0, 0, 0, 1'b1);
      chk("R2 wrap to top", random_o, 32'h0000_3F00);
      cyc(4'b0000, 1'b0, 2'd0, 0, 0, 1'b0);
      chk("R2 hold without pulse", random_o, 32'h0000_3F00);
      // R5 indexed write
      wreg(2'd0, 32'h0000_0500);
      wreg(2'd2, 32'h1234_5040);
      wreg(2'd3, 32'hABCD_E200);
      cyc(4'b0010, 1'b0, 2'd0, 0, 0, 1'b0);
      lk = 6'd5; #1;
      chk("R5 slot5 hi", lk_hi_o, 32'h1234_5040);
      chk("R5 slot5 lo", lk_lo_o, 32'hABCD_E200);
      // R10 probe right after the write
      cyc(4'b1000, 1'b0, 2'd0, 0, 0, 1'b0);
      chk("R10 probe sees fresh write", index_o, 32'h0000_0500);
      // R9 miss on other tag
      wreg(2'd2, 32'h1234_5080);
      cyc(4'b1000, 1'b0, 2'd0, 0, 0, 1'b0);
      chk("R9 probe miss", index_o, 32'h8000_0000);
      wreg(2'd0, 32'hFFFF_FFFF);
      chk("R4 index keeps miss flag", index_o, 32'h8000_3F00);
      wreg(2'd0, 32'h0000_0600);
      wreg(2'd3, 32'h1111_1100);
      cyc(4'b0010, 1'b0, 2'd0, 0, 0, 1'b0);
      // R8 global hit, then lowest-slot priority
      wreg(2'd2, 32'h1234_50C0);
      cyc(4'b1000, 1'b0, 2'd0, 0, 0, 1'b0);
      chk("R8 global hit", index_o, 32'h0000_0600);
      wreg(2'd2, 32'h1234_5040);
      cyc(4'b1000, 1'b0, 2'd0, 0, 0, 1'b0);
      chk("R8 lowest slot wins", index_o, 32'h0000_0500);
      // R6 random write with simultaneous advance
      cyc(4'b0000, 1'b0, 2'd0, 0, 0, 1'b1);
      wreg(2'd2, 32'h0AAA_A000);
      wreg(2'd3, 32'h5555_5600);
      cyc(4'b0100, 1'b0, 2'd0, 0, 0, 1'b1);
      lk = 6'd62; #1;
      chk("R6 slot62 hi", lk_hi_o, 32'h0AAA_A000);
      chk("R6 slot62 lo", lk_lo_o, 32'h5555_5600);
      chk("R6 random advanced", random_o, 32'h0000_3D00);
      // R7 read back slot 5
      cyc(4'b0001, 1'b0, 2'd0, 0, 0, 1'b0);
      chk("R7 read hi", entry_hi_o, 32'h1234_5040);
      chk("R7 read lo", entry_lo_o, 32'hABCD_E200);
      // R11 multi-bit strobe ignored
      wreg(2'd2, 32'h1234_50C0);
      cyc(4'b1001, 1'b0, 2'd0, 0, 0, 1'b0);
      chk("R11 index unchanged", index_o, 32'h0000_0500);
      chk("R11 hi unchanged", entry_hi_o, 32'h1234_50C0);
      chk("R11 lo unchanged", entry_lo_o, 32'hABCD_E200);
      // R12 probe beats same-cycle software Index write
      cyc(4'b1000, 1'b1, 2'd0, 32'h0000_3F00, 32'hFFFF_FFFF, 1'b0);
      chk("R12 probe result kept", index_o, 32'h0000_0600);
      repeat (2) @(posedge clk);
      #2;
      if (!done) begin
         done = 1'b1;
         summary();
      end
   end
endmodule